// File: doc/BRIEF.md
# Parallel Memory Bus Write-Cycle Front End

This block sits behind the pins of an asynchronous parallel memory port and translates the chip-enable, output-enable, write-enable and reset pins into clean events in a fast system clock domain. It produces the enable for the data output drivers during reads. It also recognises each write cycle and hands the rest of the device one single-cycle write strobe carrying the cycle's address and data.

Every pin, including the address and data buses, passes through a chain of flops before any decision is made. Control and buses therefore stay aligned. A write cycle can be shaped either by the write-enable pin or by the chip-enable pin. The cycle opens when the later of the two enables falls, and the address is taken at that point. The cycle closes when the earlier of the two rises, and the data is taken at that point. A bus reset pin blocks reads and writes, and a write it cuts short is dropped.

Top module: `pbw_bus_front`

## Requirements
- R1: `drv_en` is high exactly when chip enable and output enable were both low, write enable was high and the bus reset pin was high, as sampled two clock edges earlier.
- R2: `drv_en` is low whenever chip enable or output enable was high two clock edges earlier.
- R3: A write shaped by write enable (chip enable held low, write enable pulsed low, output enable high) produces one write strobe.
- R4: A write shaped by chip enable (write enable held low, chip enable pulsed low, output enable high) produces one write strobe.
- R5: `wr_addr` equals the address present when the later of the two enables fell. Address changes after that point are ignored.
- R6: `wr_data` equals the data present when the first of the two enables rose. Data changes after that rise, and the second enable's rise, are ignored.
- R7: Each write cycle yields exactly one `wr_stb` pulse, one clock wide. It is high in the third clock after the edge at which the pin rise was first sampled.
- R8: If output enable is low at the moment both enables become low, no write strobe is produced for that cycle.
- R9: While the bus reset pin is low, `drv_en` stays low and no write cycle is recognised.
- R10: A write cycle that the bus reset pin interrupts before either enable rises produces no strobe, even when the enables later rise.
- R11: While the system reset `rst_n` is low, `drv_en` and `wr_stb` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times faster than the shortest pin pulse |
| rst_n | input | 1 | System reset, asynchronous assert, active low |
| pin_ce_n | input | 1 | Chip enable pin, active low, asynchronous |
| pin_oe_n | input | 1 | Output enable pin, active low, asynchronous |
| pin_we_n | input | 1 | Write enable pin, active low, asynchronous |
| pin_rst_n | input | 1 | Bus reset pin, active low, asynchronous |
| pin_addr | input | AW | Address pins |
| pin_data | input | DW | Data input pins |
| drv_en | output | 1 | Enable for the data output drivers |
| wr_stb | output | 1 | One-cycle write event |
| wr_addr | output | AW | Address captured for the signalled write |
| wr_data | output | DW | Data captured for the signalled write |

## Verification
`drv_en` follows a pin change after two rising clock edges, because the path is two synchronizer flops and a gate. `wr_stb` follows the terminating enable rise after three edges, because a registered strobe is added to that path. The bench changes pins on falling edges. It then counts two or three rising edges before sampling on the next falling edge, and it also checks the preceding edge to confirm the result does not arrive early. A scoreboard queue receives one expected address and data pair for each write the driver completes. A monitor pops that pair on each strobe, so missing, extra and misordered strobes are all reported.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  // Control bit positions inside the synchronized control vector.
  localparam int unsigned CTRL_W  = 4;
  localparam int unsigned CI_CE   = 3;
  localparam int unsigned CI_OE   = 2;
  localparam int unsigned CI_WE   = 1;
  localparam int unsigned CI_PRST = 0;
  // Idle pin levels: enables inactive, bus reset asserted.
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 4'b1110;

  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,  // no write in progress
    CYC_OPEN = 2'd1,  // valid write cycle, address held
    CYC_HOLD = 2'd2   // enables low but cycle disqualified
  } cyc_state_e;
endpackage

// File: rtl/pbw_sync.sv
module pbw_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_comb stage_d[g] = d;
      end else begin : g_next
        always_comb stage_d[g] = stage_q[g-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= RST_VAL;
        else        stage_q[g] <= stage_d[g];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pbw_read_gate.sv
module pbw_read_gate
  import pbw_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output logic              drv_en
);
  always_comb begin
    drv_en = !ctrl[CI_CE] && !ctrl[CI_OE] && ctrl[CI_WE] && ctrl[CI_PRST];
  end
endmodule

// File: rtl/pbw_write_track.sv
module pbw_write_track
  import pbw_pkg::*;
#(
  parameter int unsigned AW = 17,
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     data,
  output logic              wr_stb,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data
);
  cyc_state_e    st_q, st_d;
  logic [AW-1:0] hold_addr_q, hold_addr_d;
  logic          addr_en;
  logic          stb_d;
  logic          out_en;

  logic both_low, bus_live, qualifies;

  always_comb begin
    both_low  = !ctrl[CI_CE] && !ctrl[CI_WE];
    bus_live  = ctrl[CI_PRST];
    qualifies = both_low && ctrl[CI_OE] && bus_live;
  end

  // Next-state logic
  always_comb begin
    st_d        = st_q;
    hold_addr_d = hold_addr_q;
    addr_en     = 1'b0;
    stb_d       = 1'b0;
    out_en      = 1'b0;
    unique case (st_q)
      CYC_IDLE: begin
        if (qualifies) begin
          st_d        = CYC_OPEN;
          hold_addr_d = addr;
          addr_en     = 1'b1;
        end else if (both_low) begin
          st_d = CYC_HOLD;
        end
      end
      CYC_OPEN: begin
        if (!bus_live) begin
          st_d = both_low ? CYC_HOLD : CYC_IDLE;
        end else if (!both_low) begin
          st_d   = CYC_IDLE;
          stb_d  = 1'b1;
          out_en = 1'b1;
        end
      end
      CYC_HOLD: begin
        if (!both_low) st_d = CYC_IDLE;
      end
      default: st_d = CYC_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CYC_IDLE;
    else        st_q <= st_d;
  end

  // Address hold register, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_addr_q <= '0;
    else if (addr_en) hold_addr_q <= hold_addr_d;
  end

  // Strobe register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_stb <= 1'b0;
    else        wr_stb <= stb_d;
  end

  // Output payload registers, clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_data <= '0;
    end else if (out_en) begin
      wr_addr <= hold_addr_q;
      wr_data <= data;
    end
  end
endmodule

// File: rtl/pbw_bus_front.sv
module pbw_bus_front
  import pbw_pkg::*;
#(
  parameter int unsigned AW          = 17,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin_ce_n,
  input  logic          pin_oe_n,
  input  logic          pin_we_n,
  input  logic          pin_rst_n,
  input  logic [AW-1:0] pin_addr,
  input  logic [DW-1:0] pin_data,
  output logic          drv_en,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  localparam int unsigned BUS_W = AW + DW;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  logic [BUS_W-1:0]  bus_raw, bus_s;

  always_comb begin
    ctrl_raw           = '0;
    ctrl_raw[CI_CE]    = pin_ce_n;
    ctrl_raw[CI_OE]    = pin_oe_n;
    ctrl_raw[CI_WE]    = pin_we_n;
    ctrl_raw[CI_PRST]  = pin_rst_n;
    bus_raw            = {pin_addr, pin_data};
  end

  pbw_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) i_ctrl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctrl_raw), .q(ctrl_s)
  );

  pbw_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
  );

  pbw_read_gate i_read_gate (
    .ctrl(ctrl_s), .drv_en(drv_en)
  );

  pbw_write_track #(.AW(AW), .DW(DW)) i_write_track (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl_s),
    .addr(bus_s[BUS_W-1:DW]), .data(bus_s[DW-1:0]),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/pbw_bus_front_chk.sv
module pbw_bus_front_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_ce_n,
  input logic pin_oe_n,
  input logic pin_we_n,
  input logic pin_rst_n,
  input logic drv_en,
  input logic wr_stb
);
  // Depths below match the default two-stage synchronizer.
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  assert_strobe_after_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(pin_ce_n, 3) || $past(pin_we_n, 3)));

  assert_drive_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_ce_n, 2) || $past(pin_oe_n, 2)) |-> !drv_en);

  assert_drive_needs_we_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    drv_en |-> $past(pin_we_n, 2));

  assert_drive_bus_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pin_rst_n, 2) |-> !drv_en);

  assert_strobe_bus_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(pin_rst_n, 3));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R11: assert (!wr_stb);
    end
  end
endmodule

bind pbw_bus_front pbw_bus_front_chk i_chk (
  .clk(clk), .rst_n(rst_n), .pin_ce_n(pin_ce_n), .pin_oe_n(pin_oe_n),
  .pin_we_n(pin_we_n), .pin_rst_n(pin_rst_n), .drv_en(drv_en), .wr_stb(wr_stb)
);

// File: tb/test_pbw_bus_front.sv
`timescale 1ns/1ps
module test_pbw_bus_front;
  localparam int unsigned AW = 17;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pin_ce_n, pin_oe_n, pin_we_n, pin_rst_n;
  logic [AW-1:0] pin_addr;
  logic [DW-1:0] pin_data;
  logic          drv_en, wr_stb;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int checks = 0;
  int errors = 0;
  int strobes_seen = 0;
  int writes_pushed = 0;
  bit done = 1'b0;
  logic [AW+DW-1:0] sb_q[$];

  always #5 clk = ~clk;

  pbw_bus_front #(.AW(AW), .DW(DW)) i_pbw_bus_front (
    .clk(clk), .rst_n(rst_n), .pin_ce_n(pin_ce_n), .pin_oe_n(pin_oe_n),
    .pin_we_n(pin_we_n), .pin_rst_n(pin_rst_n), .pin_addr(pin_addr),
    .pin_data(pin_data), .drv_en(drv_en), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compare each strobe against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      strobes_seen++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R7 unexpected strobe", {wr_addr, wr_data}, 0);
      end else begin
        logic [AW+DW-1:0] exp_item;
        exp_item = sb_q.pop_front();
        check({wr_addr, wr_data} == exp_item, "R5/R6 strobe payload", {wr_addr, wr_data}, exp_item);
      end
    end
  end

  // Write shaped by write enable (R3); junk address after the fall, junk data after the rise.
  task automatic we_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit timing);
    pin_addr = a; pin_ce_n = 1'b0; tick(3);
    pin_we_n = 1'b0; tick(3);
    pin_addr = ~a; pin_data = d; tick(3);   // R5: later address ignored
    sb_q.push_back({a, d}); writes_pushed++;
    pin_we_n = 1'b1;
    if (timing) begin
      tick(2); check(wr_stb == 1'b0, "R7 strobe early", wr_stb, 0);
      tick(1); check(wr_stb == 1'b1, "R3 strobe due", wr_stb, 1);
      tick(1); check(wr_stb == 1'b0, "R7 strobe width", wr_stb, 0);
    end else begin
      tick(4);
    end
    pin_data = ~d; tick(2);                  // R6: later data ignored
    pin_ce_n = 1'b1; tick(4);
  endtask

  // Write shaped by chip enable (R4); write enable stays low across both rises.
  task automatic ce_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    pin_addr = ~a; pin_we_n = 1'b0; tick(3);
    pin_addr = a; tick(2);
    pin_ce_n = 1'b0; tick(3);
    pin_addr = a ^ 1; pin_data = d; tick(3);
    sb_q.push_back({a, d}); writes_pushed++;
    pin_ce_n = 1'b1; tick(4);
    pin_data = ~d; tick(3);
    pin_we_n = 1'b1; tick(5);                // second rise: no strobe (R6)
  endtask

  initial begin
    rst_n = 1'b0;
    pin_ce_n = 1'b1; pin_oe_n = 1'b1; pin_we_n = 1'b1; pin_rst_n = 1'b1;
    pin_addr = '0; pin_data = '0;
    tick(3);
    check(drv_en == 1'b0, "R11 drv_en in reset", drv_en, 0);
    check(wr_stb == 1'b0, "R11 wr_stb in reset", wr_stb, 0);
    rst_n = 1'b1; tick(3);

    // Read gating R1 / R2
    pin_ce_n = 1'b0; pin_oe_n = 1'b0;
    tick(1); check(drv_en == 1'b0, "R1 drv_en early", drv_en, 0);
    tick(1); check(drv_en == 1'b1, "R1 drv_en on", drv_en, 1);
    pin_oe_n = 1'b1; tick(2);
    check(drv_en == 1'b0, "R2 oe high", drv_en, 0);
    pin_oe_n = 1'b0; tick(2);
    check(drv_en == 1'b1, "R1 drv_en again", drv_en, 1);
    pin_ce_n = 1'b1; tick(2);
    check(drv_en == 1'b0, "R2 ce high", drv_en, 0);
    pin_oe_n = 1'b1; tick(2);

    // Writes R3, R4, R5, R6, R7
    we_write(17'h1_2345, 8'hA5, 1'b1);
    ce_write(17'h0_0F0F, 8'h3C);
    for (int i = 0; i < 4; i++) begin
      we_write(17'(i * 17'h4321 + 7), 8'(i * 37 + 1), 1'b0);
      ce_write(17'(i * 17'h0777 + 3), 8'(8'hF0 ^ i));
    end

    // R8: output enable low while both enables low
    pin_oe_n = 1'b0; pin_ce_n = 1'b0; tick(3);
    pin_we_n = 1'b0; tick(3);
    check(drv_en == 1'b0, "R1 no drive while we low", drv_en, 0);
    pin_oe_n = 1'b1; tick(3);
    pin_we_n = 1'b1; tick(4);
    check(strobes_seen == writes_pushed, "R8 no strobe", strobes_seen, writes_pushed);
    pin_ce_n = 1'b1; tick(3);

    // R9: bus reset low blocks reads and writes
    pin_rst_n = 1'b0; pin_ce_n = 1'b0; pin_oe_n = 1'b0; tick(3);
    check(drv_en == 1'b0, "R9 drv_en under bus reset", drv_en, 0);
    pin_oe_n = 1'b1; pin_we_n = 1'b0; tick(3);
    pin_we_n = 1'b1; tick(4);
    check(strobes_seen == writes_pushed, "R9 no strobe under bus reset", strobes_seen, writes_pushed);
    pin_ce_n = 1'b1; tick(2);
    pin_rst_n = 1'b1; tick(3);

    // R10: write interrupted by bus reset
    pin_addr = 17'h0_0ABC; pin_data = 8'h77; pin_ce_n = 1'b0; tick(3);
    pin_we_n = 1'b0; tick(3);
    pin_rst_n = 1'b0; tick(3);
    pin_rst_n = 1'b1; tick(3);
    pin_we_n = 1'b1; tick(4);
    pin_ce_n = 1'b1; tick(3);
    check(strobes_seen == writes_pushed, "R10 interrupted write dropped", strobes_seen, writes_pushed);

    // Recovery write after interruption
    we_write(17'h1_FFFF, 8'h00, 1'b1);
    tick(3);
    check(sb_q.size() == 0, "R7 missing strobes", sb_q.size(), 0);
    check(strobes_seen == writes_pushed, "R7 strobe count", strobes_seen, writes_pushed);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule